// File: doc/BRIEF.md
# Cascadable Dual Period-Match Timer

The block holds two 8-bit up-counters, A and B, each paired with its own 8-bit period register. A counter advances on each tick while enabled; once it equals its period, the following tick returns it to zero and sets a sticky interrupt flag. A join bit fuses the pair into a single 16-bit timer, with B as the high byte and the two period registers forming a 16-bit period in the same order.

Ticks come from one of two sources. The internal source is an enable pulse that fires once every four system clocks. The external source is a falling edge on an input pin, which is synchronized before use. The counter always runs on the system clock; the tick only gates its update.

A small register port reads and writes the counters, periods, control bits and flags. Interrupt flags are also driven straight to two output pins.

Top module: `dual_match_timer`

## Requirements
- R1: Register map, addressed by `addr`, with `rd_data` combinational from `addr`: 0 counter A, 1 counter B, 2 period A, 3 period B, 4 control, 5 flags, other addresses read zero. The control bits are: bit0 enable A, bit1 enable B, bit2 source A (1 = external), bit3 source B (1 = external), bit4 join. The flags register has bit0 for flag A and bit1 for flag B.
- R2: After reset, the counters, periods, control and flags all read zero.
- R3: With join clear, each timer counts its own ticks under its own enable, source and period. On the tick after a match, that timer goes to zero and sets its own flag.
- R4: With join set and both enables set, {B,A} counts as one 16-bit value and the low byte carries into the high byte. On the tick after {B,A} equals {period B, period A}, both bytes go to zero and flag A is set. Flag B is untouched.
- R5: With join set, source A selects the tick for the whole 16-bit counter, and source B has no effect.
- R6: With join set, enable A set and enable B clear, only the low byte advances. It wraps from 255 to 0 with no flag, and the high byte holds. With join set and enable A clear, the counter holds.
- R7: The internal tick fires once every 4 clocks. A timer enabled for exactly 40 clock edges advances exactly 10 times.
- R8: The external pin passes through a two-stage synchronizer and a falling-edge detector. Each falling edge counts once, and the counter changes at the third rising clock edge after the pin falls.
- R9: A flag stays set until a write of 1 to its bit in the flags register. If a set and a clear fall in the same cycle, the set wins.
- R10: A write to a counter or period is visible on the next cycle and takes priority over a tick in the same cycle. With a period of zero, every tick sets the flag and the counter stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External tick pin, asynchronous, counted on falling edges |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq_a | output | 1 | Flag of timer A (also the 16-bit flag) |
| irq_b | output | 1 | Flag of timer B |

## Verification
The hardest case to reach is a flag clear that lands in the very cycle a match tick sets the same flag, because the tick has to be placed exactly. The bench sets period A to zero and uses the external source, so that every falling edge on the pin is a flag-setting tick. It then starts the clearing write two clocks after the pin falls, which places the write on the same rising edge as the tick. The exact 40-edge window for the internal rate and the sample taken just before the external count changes rely on the same counting of register stages.

// File: rtl/dual_match_timer.sv
`timescale 1ns/1ps
module dual_match_timer #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         irq_a,
  output logic         irq_b
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_a, cnt_b, per_a, per_b;
  logic         en_a, en_b, sel_a, sel_b, join16, flag_a, flag_b;
  logic [DW-1:0] div;
  logic         s1, s2, s3;

  // tick sources
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= (div == DW'(DIV-1)) ? '0 : div + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {ext_clk, s1, s2};

  wire int_tick = (div == DW'(DIV-1));
  wire ext_tick = s3 & ~s2;
  wire tick_a   = sel_a ? ext_tick : int_tick;
  wire tick_b   = sel_b ? ext_tick : int_tick;

  // register decode
  wire wr_ca  = wr_en && addr == 3'd0;
  wire wr_cb  = wr_en && addr == 3'd1;
  wire wr_pa  = wr_en && addr == 3'd2;
  wire wr_pb  = wr_en && addr == 3'd3;
  wire wr_ctl = wr_en && addr == 3'd4;
  wire wr_flg = wr_en && addr == 3'd5;

  // counting
  wire [2*W-1:0] wide   = {cnt_b, cnt_a};
  wire           run16  = join16 & en_a & en_b & tick_a;
  wire           lo_run = join16 & en_a & ~en_b & tick_a;
  wire           run_a  = ~join16 & en_a & tick_a;
  wire           run_b  = ~join16 & en_b & tick_b;

  logic [W-1:0] nxt_a, nxt_b;
  logic         set_a, set_b;

  always_comb begin
    nxt_a = cnt_a;
    nxt_b = cnt_b;
    set_a = 1'b0;
    set_b = 1'b0;
    if (run16) begin
      if (wide == {per_b, per_a}) begin
        {nxt_b, nxt_a} = '0;
        set_a = 1'b1;
      end else begin
        {nxt_b, nxt_a} = wide + 1'b1;
      end
    end else if (lo_run) begin
      nxt_a = cnt_a + 1'b1;
    end else begin
      if (run_a) begin
        set_a = (cnt_a == per_a);
        nxt_a = set_a ? '0 : cnt_a + 1'b1;
      end
      if (run_b) begin
        set_b = (cnt_b == per_b);
        nxt_b = set_b ? '0 : cnt_b + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_a <= '0; cnt_b <= '0; per_a <= '0; per_b <= '0;
      {join16, sel_b, sel_a, en_b, en_a} <= '0;
      flag_a <= 1'b0; flag_b <= 1'b0;
    end else begin
      cnt_a  <= wr_ca ? wr_data : nxt_a;
      cnt_b  <= wr_cb ? wr_data : nxt_b;
      if (wr_pa)  per_a <= wr_data;
      if (wr_pb)  per_b <= wr_data;
      if (wr_ctl) {join16, sel_b, sel_a, en_b, en_a} <= wr_data[4:0];
      flag_a <= set_a | (flag_a & ~(wr_flg & wr_data[0]));
      flag_b <= set_b | (flag_b & ~(wr_flg & wr_data[1]));
    end

  always_comb
    case (addr)
      3'd0:    rd_data = cnt_a;
      3'd1:    rd_data = cnt_b;
      3'd2:    rd_data = per_a;
      3'd3:    rd_data = per_b;
      3'd4:    rd_data = W'({join16, sel_b, sel_a, en_b, en_a});
      3'd5:    rd_data = W'({flag_b, flag_a});
      default: rd_data = '0;
    endcase

  assign irq_a = flag_a;
  assign irq_b = flag_b;

  // checks
  p_int_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_tick |=> !int_tick);

  p_wrap16_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run16 && wide == {per_b, per_a} && !wr_en) |=> (cnt_a == '0 && cnt_b == '0 && flag_a));

  p_hold_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (join16 && en_a && !en_b && !wr_en) |=> $stable(cnt_b));

  p_stop16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (join16 && !en_a && !wr_en) |=> ($stable(cnt_a) && $stable(cnt_b)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !(wr_en && addr == 3'd5 && wr_data[0])) |=> flag_a);
endmodule

// File: tb/dual_match_timer_test.sv
`timescale 1ns/1ps
module dual_match_timer_test;
  logic clk = 0, rst_n = 0, ext_clk = 0, wr_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_a, irq_b;
  logic sample_req = 0;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dual_match_timer uut (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_a(irq_a), .irq_b(irq_b));

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    sample_req = 1;
    @(negedge clk);
    sample_req = 0;
  endtask

  task automatic pulse();
    ext_clk = 1; repeat (3) @(negedge clk);
    ext_clk = 0; repeat (3) @(negedge clk);
  endtask

  // monitor: pops expected items and compares
  always @(negedge clk) begin
    #1;
    if (sample_req && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state, R1 map
    rd(3'd0, 8'h00, "R2 cnt_a reset");
    rd(3'd3, 8'h00, "R2 per_b reset");
    rd(3'd4, 8'h00, "R2 ctl reset");
    rd(3'd5, 8'h00, "R2 flags reset");
    rd(3'd6, 8'h00, "R1 unused addr");

    // R3 independent 8-bit timers, external source
    wr(3'd2, 8'd2); wr(3'd3, 8'd1);
    rd(3'd2, 8'd2, "R10 period write visible");
    wr(3'd4, 8'h0F);
    rd(3'd4, 8'h0F, "R1 ctl readback");
    pulse(); pulse();
    rd(3'd0, 8'd2, "R3 a at period");
    rd(3'd1, 8'd0, "R3 b wrapped");
    rd(3'd5, 8'h02, "R3 only flag b");
    pulse();
    rd(3'd0, 8'd0, "R3 a cleared after match");
    rd(3'd1, 8'd1, "R3 b counting");
    rd(3'd5, 8'h03, "R3 both flags");
    // R9 sticky, write-1 clear
    wr(3'd5, 8'h01);
    rd(3'd5, 8'h02, "R9 clear flag a only");
    wr(3'd5, 8'h02);
    rd(3'd5, 8'h00, "R9 clear flag b");

    // R8 latency
    wr(3'd4, 8'h00); wr(3'd2, 8'hFF); wr(3'd0, 8'h10);
    rd(3'd0, 8'h10, "R10 counter write visible");
    wr(3'd4, 8'h05);
    ext_clk = 1; repeat (3) @(negedge clk);
    ext_clk = 0; @(negedge clk); @(negedge clk);
    rd(3'd0, 8'h10, "R8 not yet at second edge");
    rd(3'd0, 8'h11, "R8 counted at third edge");

    // R10 period zero, R9 set beats clear
    wr(3'd4, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h00); wr(3'd4, 8'h05);
    pulse();
    rd(3'd0, 8'h00, "R10 period zero count stays 0");
    rd(3'd5, 8'h01, "R10 period zero flag");
    ext_clk = 1; repeat (3) @(negedge clk);
    ext_clk = 0; @(negedge clk); @(negedge clk);
    wr(3'd5, 8'h01);
    rd(3'd5, 8'h01, "R9 set wins over clear");
    wr(3'd5, 8'h01);
    rd(3'd5, 8'h00, "R9 clear without set");

    // R4/R5 16-bit
    wr(3'd4, 8'h00); wr(3'd2, 8'h02); wr(3'd3, 8'h01);
    wr(3'd0, 8'hFF); wr(3'd1, 8'h00); wr(3'd5, 8'h03);
    wr(3'd4, 8'h17);
    repeat (20) @(negedge clk);
    rd(3'd0, 8'hFF, "R5 source b ignored");
    pulse();
    rd(3'd0, 8'h00, "R4 low byte wraps");
    rd(3'd1, 8'h01, "R4 carry into high");
    pulse(); pulse();
    rd(3'd0, 8'h02, "R4 at 16-bit period low");
    rd(3'd5, 8'h00, "R4 no flag at match");
    pulse();
    rd(3'd0, 8'h00, "R4 cleared low");
    rd(3'd1, 8'h00, "R4 cleared high");
    rd(3'd5, 8'h01, "R4 flag a only");
    if (irq_a !== 1'b1 || irq_b !== 1'b0) begin
      errors++; $display("FAIL R4 irq pins: got %b%b expected 10", irq_a, irq_b);
    end
    checks++;

    // R6 enable combinations
    wr(3'd4, 8'h00); wr(3'd0, 8'hFF); wr(3'd1, 8'h05); wr(3'd5, 8'h03);
    wr(3'd4, 8'h15);
    pulse();
    rd(3'd0, 8'h00, "R6 low only wraps");
    rd(3'd1, 8'h05, "R6 high held");
    rd(3'd5, 8'h00, "R6 no flag low only");
    pulse();
    rd(3'd0, 8'h01, "R6 low only counts");
    wr(3'd4, 8'h16);
    pulse();
    rd(3'd0, 8'h01, "R6 stopped low");
    rd(3'd1, 8'h05, "R6 stopped high");

    // R7 internal rate
    wr(3'd4, 8'h00); wr(3'd2, 8'hFF); wr(3'd0, 8'h00);
    wr(3'd4, 8'h01);
    repeat (39) @(negedge clk);
    wr(3'd4, 8'h00);
    rd(3'd0, 8'd10, "R7 ten ticks in 40 edges");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule